// File: doc/BRIEF.md
# Programmable Down Counter with Pulse-Width Output

This block is an 8-bit down counter that can also serve as a pulse-width modulator. A host reaches five registers through a small synchronous register port. Three of them hold data: the period, the threshold and the live count. A control register starts and stops the function, and a mode register picks the comparison operator and the interrupt source. Counting advances on a single-cycle source tick, and only while a count-enable input is high. That input passes through a two-flop synchronizer before use.

On each tick the count steps down by one. When it has reached zero, the next tick reloads it from the period register. This reload happens even if the enable fell in the same period, and the counter then stops there. The threshold output is registered one cycle after each tick, which gives a duty cycle set by the ratio of threshold to period. A terminal-count output serves as a carry-out. A carry-in gates both the decrement and the terminal count, so stages can be chained into wider counters in 8-bit steps. An interrupt request pulses for one cycle on the rising edge of whichever output the mode register selects.

Top module: `pwm_down_counter`

## Requirements
- R1: Reset (synchronous, active high) clears the count, period, threshold, control and mode registers, and holds `cmp_out`, `tc_out` and `irq` low.
- R2: Register addresses are 1 = period, 2 = threshold, 3 = control (bit 0 = run), 4 = mode (bit 0 = interrupt on threshold output, bit 1 = less-or-equal compare). These registers read back what was written, and unused bits read as 0.
- R3: While run is 0, a write to the period register also loads the count, and the count does not change on ticks.
- R4: A read of address 0 (count) always returns 0. While run is 0, that read also copies the count into the threshold register and replaces its previous value.
- R5: With run high, the synchronized enable high and `carry_in` high, each tick lowers the count by one. The enable takes effect two clock cycles after it changes at the pin.
- R6: With run high and the synchronized enable low, a tick leaves a nonzero count unchanged.
- R7: With run high, a tick at terminal count reloads the count from the period register whatever the enable is. With the enable low, the count then holds at the period value.
- R8: `tc_out` is high exactly when run is 1, the count is 0 and `carry_in` is 1.
- R9: In the cycle after a tick, `cmp_out` is registered as count < threshold when mode bit 1 is 0, or as count <= threshold when mode bit 1 is 1. At other times it holds.
- R10: `irq` is high for one cycle when the selected source rises. The source is `tc_out` when mode bit 0 is 0 and `cmp_out` when mode bit 0 is 1.
- R11: With `carry_in` low, a tick does not decrement a nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| src_tick | input | 1 | Single-cycle source clock tick |
| cnt_en | input | 1 | Asynchronous count enable |
| carry_in | input | 1 | Chain input from the lower stage's terminal count (tie high when standalone) |
| cmp_out | output | 1 | Registered threshold comparison result |
| tc_out | output | 1 | Terminal count, also the carry-out |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions check the step rules on every cycle: a decrement, a hold or a reload on each tick, and a frozen count while the function is stopped. They also check that the threshold output never moves outside the cycle after a tick and that the interrupt never lasts two cycles. Only the bench's scenarios can show the rest. These are the destructive count readback, the late reload after the enable has fallen at terminal count, the two-cycle enable latency, and the agreement of the comparison and interrupt outputs with an independent model under random tick, enable and carry patterns.

// File: rtl/pwmcnt_pkg.sv
package pwmcnt_pkg;

    typedef enum logic [2:0] {
        A_COUNT   = 3'd0,
        A_PERIOD  = 3'd1,
        A_THRESH  = 3'd2,
        A_CTRL    = 3'd3,
        A_MODE    = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic cmp_le;      // bit 1: less-or-equal compare
        logic irq_on_cmp;  // bit 0: interrupt source is the threshold output
    } mode_t;

    function automatic logic cmp_hit(input logic [31:0] cnt,
                                     input logic [31:0] thr,
                                     input logic        le);
        return le ? (cnt <= thr) : (cnt < thr);
    endfunction

endpackage

// File: rtl/pwmcnt_sync.sv
module pwmcnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwmcnt_regs.sv
module pwmcnt_regs
    import pwmcnt_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  count,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  period,
    output logic [W-1:0]  thresh,
    output logic          run,
    output mode_t         mode,
    output logic          load,
    output logic [W-1:0]  load_val
);
    localparam int MODE_BITS = $bits(mode_t);

    assign load     = wr && (addr == A_PERIOD) && !run;
    assign load_val = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
            thresh <= '0;
            run    <= 1'b0;
            mode   <= '0;
        end else begin
            if (wr && addr == A_PERIOD) period <= wdata;
            if (wr && addr == A_CTRL)   run    <= wdata[0];
            if (wr && addr == A_MODE)   mode   <= mode_t'(wdata[MODE_BITS-1:0]);
            if (wr && addr == A_THRESH)
                thresh <= wdata;
            else if (rd && addr == A_COUNT && !run)
                thresh <= count;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_PERIOD: rdata = period;
            A_THRESH: rdata = thresh;
            A_CTRL:   rdata = {{(W-1){1'b0}}, run};
            A_MODE:   rdata = {{(W-MODE_BITS){1'b0}}, mode};
            default:  rdata = '0;
        endcase
    end

    // R4: a stopped count read moves the count into the threshold register
    a_r4_copy: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && addr == A_COUNT && !run) |=> (thresh == $past(count)));
endmodule

// File: rtl/pwmcnt_core.sv
module pwmcnt_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         en_s,
    input  logic         cin,
    input  logic [W-1:0] period,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         tc
);
    logic zero;
    assign zero = (count == '0);
    assign tc   = run && zero && cin;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick && run) begin
            if (tc)
                count <= period;
            else if (en_s && cin)
                count <= count - 1'b1;
        end
    end

    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(count));
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (run && tick && en_s && cin && !zero) |=> (count == W'($past(count) - 1'b1)));
    a_r6_hold_no_enable: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !en_s && !zero && !load) |=> $stable(count));
    a_r7_reload: assert property (@(posedge clk) disable iff (rst)
        (run && tick && tc && !load) |=> (count == $past(period)));
    a_r11_no_carry: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !cin && !load) |=> $stable(count));
endmodule

// File: rtl/pwmcnt_out.sv
module pwmcnt_out
    import pwmcnt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic [W-1:0] thresh,
    input  mode_t        mode,
    input  logic         tc,
    output logic         cmp_out,
    output logic         irq
);
    logic tick_d;
    logic sel, sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_d  <= 1'b0;
            cmp_out <= 1'b0;
            sel_q   <= 1'b0;
        end else begin
            tick_d <= tick;
            sel_q  <= sel;
            if (tick_d)
                cmp_out <= cmp_hit(32'(count), 32'(thresh), mode.cmp_le);
        end
    end

    assign sel = mode.irq_on_cmp ? cmp_out : tc;
    assign irq = sel && !sel_q;

    a_r9_cmp_only_after_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_d |=> $stable(cmp_out));
    a_r10_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter
    import pwmcnt_pkg::*;
#(
    parameter int W          = 8,
    parameter int AW         = 3,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic          src_tick,
    input  logic          cnt_en,
    input  logic          carry_in,
    output logic          cmp_out,
    output logic          tc_out,
    output logic          irq
);
    logic [W-1:0] count, period, thresh, load_val;
    logic         run, load, en_s;
    mode_t        mode;

    pwmcnt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .din(cnt_en), .dout(en_s)
    );

    pwmcnt_regs #(.W(W), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .count(count), .rdata(bus_rdata),
        .period(period), .thresh(thresh), .run(run), .mode(mode),
        .load(load), .load_val(load_val)
    );

    pwmcnt_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .tick(src_tick), .run(run), .en_s(en_s),
        .cin(carry_in), .period(period), .load(load), .load_val(load_val),
        .count(count), .tc(tc_out)
    );

    pwmcnt_out #(.W(W)) u_out (
        .clk(clk), .rst(rst), .tick(src_tick), .count(count), .thresh(thresh),
        .mode(mode), .tc(tc_out), .cmp_out(cmp_out), .irq(irq)
    );

    // R1: outputs quiet while reset is applied
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!cmp_out && !tc_out && !irq));
endmodule

// File: tb/test_pwm_down_counter.sv
module test_pwm_down_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       src_tick = 1'b0, cnt_en = 1'b0, carry_in = 1'b1;
    logic       cmp_out, tc_out, irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pwm_down_counter i_pwm_down_counter (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick(src_tick), .cnt_en(cnt_en), .carry_in(carry_in),
        .cmp_out(cmp_out), .tc_out(tc_out), .irq(irq)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); src_tick = 1'b1;
            @(negedge clk); src_tick = 1'b0;
        end
    endtask

    // stop, read the count (must return 0), then fetch it from the threshold register
    task automatic peek_count(input string req, input int exp);
        logic [7:0] d;
        wr_reg(3'd3, 8'd0);
        rd_reg(3'd0, d);
        chk(d == 8'd0, "R4", d, 0);
        rd_reg(3'd2, d);
        chk(d == exp[7:0], req, d, exp);
    endtask

    function automatic logic exp_cmp(input int cnt, input int thr, input logic le);
        return le ? (cnt <= thr) : (cnt < thr);
    endfunction

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        process::self().srandom(32'd1234);
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!cmp_out && !tc_out && !irq, "R1", {cmp_out, tc_out, irq}, 0);
        for (int a = 1; a <= 4; a++) begin
            rd_reg(3'(a), d);
            chk(d == 0, "R1", d, 0);
        end

        // R2 register access
        wr_reg(3'd1, 8'hA5); rd_reg(3'd1, d); chk(d == 8'hA5, "R2", d, 8'hA5);
        wr_reg(3'd2, 8'h3C); rd_reg(3'd2, d); chk(d == 8'h3C, "R2", d, 8'h3C);
        wr_reg(3'd3, 8'hFF); rd_reg(3'd3, d); chk(d == 8'h01, "R2", d, 1);
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd4, 8'hFF); rd_reg(3'd4, d); chk(d == 8'h03, "R2", d, 3);
        wr_reg(3'd4, 8'h00);

        // R3 period write loads count while stopped
        wr_reg(3'd1, 8'd6);
        peek_count("R3", 6);
        // R3/R4 count frozen while stopped, threshold overwritten by readback
        cnt_en = 1'b1;
        wr_reg(3'd2, 8'h11);
        ticks(3);
        peek_count("R4", 6);

        // R5 decrement with enable after synchronizer latency
        idle(4);
        wr_reg(3'd3, 8'd1);
        ticks(2);
        peek_count("R5", 4);

        // R6 hold with enable low
        cnt_en = 1'b0; idle(4);
        wr_reg(3'd3, 8'd1);
        ticks(3);
        peek_count("R6", 4);

        // R11 carry-in low blocks decrement
        cnt_en = 1'b1; carry_in = 1'b0; idle(4);
        wr_reg(3'd3, 8'd1);
        ticks(2);
        peek_count("R11", 4);

        // R7 reload at terminal count after enable falls
        carry_in = 1'b1;
        wr_reg(3'd3, 8'd1);
        ticks(4);
        @(negedge clk);
        chk(tc_out == 1'b1, "R8", tc_out, 1);
        cnt_en = 1'b0; idle(3);
        ticks(1);
        chk(tc_out == 1'b0, "R7", tc_out, 0);
        ticks(2);
        peek_count("R7", 6);

        // R8/R10 terminal count gating and interrupt on its rising edge
        wr_reg(3'd1, 8'd0);
        carry_in = 1'b0;
        wr_reg(3'd3, 8'd1);
        @(negedge clk);
        chk(tc_out == 1'b0, "R8", tc_out, 0);
        chk(irq == 1'b0, "R10", irq, 0);
        carry_in = 1'b1;
        #1;
        chk(tc_out == 1'b1, "R8", tc_out, 1);
        chk(irq == 1'b1, "R10", irq, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R10", irq, 0);
        wr_reg(3'd3, 8'd0);
        @(negedge clk);
        chk(tc_out == 1'b0, "R8", tc_out, 0);

        // Random segments against a bench model (R5, R8, R9, R10)
        for (int seg = 0; seg < 4; seg++) begin
            int   m_cnt, m_per, m_thr;
            logic m_le, m_icmp, m_s1, m_s2, m_tickd, m_cmp, m_selq;
            logic n_tick, n_en, n_cin, ens, m_tc, m_sel;
            m_per  = $urandom_range(0, 40);
            m_thr  = $urandom_range(0, 40);
            m_le   = 1'($urandom_range(0, 1));
            m_icmp = 1'($urandom_range(0, 1));
            src_tick = 1'b0; cnt_en = 1'b1; carry_in = 1'b1;
            wr_reg(3'd3, 8'd0);
            wr_reg(3'd1, 8'(m_per));
            wr_reg(3'd2, 8'(m_thr));
            wr_reg(3'd4, {6'd0, m_le, m_icmp});
            wr_reg(3'd3, 8'd1);
            idle(4);
            m_cnt = m_per; m_s1 = 1'b1; m_s2 = 1'b1; m_tickd = 1'b0;
            m_cmp = cmp_out;
            m_selq = m_icmp ? cmp_out : tc_out;
            for (int c = 0; c < 800; c++) begin
                m_tc  = (m_cnt == 0) && carry_in;
                m_sel = m_icmp ? m_cmp : m_tc;
                chk(cmp_out == m_cmp, "R9", cmp_out, m_cmp);
                chk(tc_out == m_tc, "R8", tc_out, m_tc);
                chk(irq == (m_sel && !m_selq), "R10", irq, m_sel && !m_selq);
                n_tick = ($urandom_range(0, 99) < 40);
                n_en   = ($urandom_range(0, 99) < 3) ? !cnt_en : cnt_en;
                n_cin  = ($urandom_range(0, 99) >= 10);
                src_tick = n_tick; cnt_en = n_en; carry_in = n_cin;
                // model the coming clock edge
                m_tc   = (m_cnt == 0) && n_cin;
                m_selq = m_icmp ? m_cmp : m_tc;
                ens = m_s2; m_s2 = m_s1; m_s1 = n_en;
                if (m_tickd) m_cmp = exp_cmp(m_cnt, m_thr, m_le);
                m_tickd = n_tick;
                if (n_tick) begin
                    if (m_tc) m_cnt = m_per;
                    else if (ens && n_cin) m_cnt = m_cnt - 1;
                end
                @(negedge clk);
            end
            src_tick = 1'b0;
            peek_count("R5", m_cnt);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule